// File: doc/BRIEF.md
# Segmented Pre/Post-Trigger Capture Controller

This block sits between a sampled digital data stream and a circular sample memory. It decides which samples are written, where they land, and when a recording is complete. One memory write is issued per recorded sample, one cycle after that sample is presented. The block marks the trigger position inside each record and reports its progress on three status lines.

There are three modes. In single-shot mode the whole memory is one ring, written continuously until a trigger, after which a programmed post-trigger count finishes the record. In multi-record mode the memory is divided into equal segments, and each accepted trigger fills the current segment and moves to the next one. In gated mode a record opens when an external gate reaches its programmed level, continues while the gate stays there, and closes after a post area once the gate leaves that level. Every length is given in blocks of 32 samples. Between records the block enforces a fixed re-arm gap followed by a fresh pre-trigger fill, and it flags any trigger that arrives too early.

Top module: `capseg_ctrl`

## Requirements
- R1: After reset `armed`, `triggered`, `done`, `missed`, `wr_en` and `tpos_valid` are 0. Valid samples and triggers presented before the first `arm` pulse produce no write.
- R2: A sample counts only in a cycle with `smp_valid`=1. When it is recorded, `wr_en` is 1 in the next cycle with `wr_data` equal to that sample. A cycle with `smp_valid`=0 neither writes nor accepts a trigger.
- R3: With `cfg_mode`=0 (single-shot) the segment is the whole memory of 2^ADDR_W samples. `armed` rises after 2^ADDR_W − post samples have been recorded since `arm`. The sample carrying the accepted trigger is the first of `post` recorded samples. `done` then rises, and sample k since `arm` lands at address k mod 2^ADDR_W.
- R4: The pre, post and segment lengths are `cfg_pre_blk`×32, `cfg_post_blk`×32 and `cfg_seg_blk`×32 samples.
- R5: With `cfg_mode`=1 (multi-record) segment s starts at address s×seg. Inside a segment the address advances by one per recorded sample and wraps to the segment start after seg samples.
- R6: When a segment ends (multi-record or gated), the next 40 valid samples are not written. The following pre samples are written to the new segment, and `armed` rises only after them.
- R7: A trigger (or gate start in gated mode) that arrives while the pre area is filling or during the re-arm gap is ignored. It sets `missed`, which stays 1 until the next `arm` pulse.
- R8: With `cfg_mode`=2 (gated), a record opens on the first valid sample at which `gate`==`cfg_gate_lvl` while the previous valid sample had the other level. Recording continues while the gate holds that level. The first sample with the gate off starts a post area of `post` samples.
- R9: After `cfg_seg_num` records (one in single-shot mode), `done` is 1 and no further writes occur. An `arm` pulse clears `done` and `missed` and restarts at segment 0 with an empty pre area. The sample in the `arm` cycle is not recorded.
- R10: For each accepted trigger, `tpos_valid` pulses for one cycle, in the cycle that sample is written, with `tpos_addr` equal to its write address.
- R11: At most one of `armed`, `triggered`, `done` is 1 at any time. `triggered` is 1 while post or gate samples are being recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm | input | 1 | Start pulse; restarts the capture at segment 0 |
| cfg_mode | input | 2 | 0 single-shot, 1 multi-record, 2 gated |
| cfg_pre_blk | input | PRE_BLK_W | Pre-trigger length in 32-sample blocks (multi/gated) |
| cfg_post_blk | input | SEG_BLK_W | Post-trigger length in 32-sample blocks |
| cfg_seg_blk | input | SEG_BLK_W | Segment length in 32-sample blocks (multi/gated) |
| cfg_seg_num | input | NSEG_W | Number of records before done (multi/gated) |
| cfg_gate_lvl | input | 1 | Gate level that opens a record |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | SMP_W | Sample value |
| trig | input | 1 | Trigger strobe, qualified by smp_valid |
| gate | input | 1 | External gate |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | SMP_W | Memory write data |
| armed | output | 1 | Pre area full, waiting for a trigger |
| triggered | output | 1 | Recording post or gate samples |
| done | output | 1 | All records complete |
| missed | output | 1 | Sticky: an early trigger was ignored |
| tpos_valid | output | 1 | Trigger position strobe |
| tpos_addr | output | ADDR_W | Address of the trigger sample |

## Verification
The hardest situation to reach is a segment in which the armed wait runs long enough for the write pointer to wrap inside the segment before the post area closes. Only then does the modulo addressing matter, and only then does older pre data get overwritten within a non-zero segment base. The multi-record scenario streams an exact sample-indexed ramp and delays the third trigger until the pointer sits eight samples from the segment end. The post area therefore wraps, and the bench can name the sample expected at every boundary address. Early triggers are also placed on the last gap sample region and inside the pre fill, so that the re-arm window is probed from both sides.

// File: rtl/capseg_pkg.sv
package capseg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_FILL,
        ST_ARMED,
        ST_POST,
        ST_GATE,
        ST_DONE
    } cap_state_e;

    localparam logic [1:0] MODE_SINGLE = 2'd0;
    localparam logic [1:0] MODE_MULTI  = 2'd1;
    localparam logic [1:0] MODE_GATED  = 2'd2;

endpackage

// File: rtl/capseg_len.sv
module capseg_len
    import capseg_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int BLK_LOG   = 5,
    parameter int PRE_BLK_W = 8,
    parameter int SEG_BLK_W = 6,
    parameter int CNT_W     = 14
) (
    input  logic [1:0]           mode,
    input  logic [PRE_BLK_W-1:0] pre_blk,
    input  logic [SEG_BLK_W-1:0] post_blk,
    input  logic [SEG_BLK_W-1:0] seg_blk,
    output logic [CNT_W-1:0]     fill_need,
    output logic [CNT_W-1:0]     post_len,
    output logic [CNT_W-1:0]     seg_len
);

    localparam logic [CNT_W-1:0] DEPTH = CNT_W'(1) << ADDR_W;

    always_comb begin
        post_len = CNT_W'(post_blk) << BLK_LOG;
        if (mode == MODE_SINGLE) begin
            // whole ring minus the post area is usable as pre-trigger history
            fill_need = DEPTH - post_len;
            seg_len   = DEPTH;
        end else begin
            fill_need = CNT_W'(pre_blk) << BLK_LOG;
            seg_len   = CNT_W'(seg_blk) << BLK_LOG;
        end
    end

endmodule

// File: rtl/capseg_event.sv
module capseg_event
    import capseg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic [1:0] mode,
    input  logic       gate_lvl,
    input  logic       smp_valid,
    input  logic       trig,
    input  logic       gate,
    output logic       hit,
    output logic       gate_on
);

    logic gp_d, gp_q;

    always_comb begin
        gate_on = (gate == gate_lvl);
        gp_d    = gp_q;
        if (arm) begin
            gp_d = 1'b1;          // a gate already open at arm is not an edge
        end else if (smp_valid) begin
            gp_d = gate_on;
        end
        if (mode == MODE_GATED) begin
            hit = smp_valid && gate_on && !gp_q;
        end else begin
            hit = smp_valid && trig;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gp_q <= 1'b1;
        end else begin
            gp_q <= gp_d;
        end
    end

endmodule

// File: rtl/capseg_ctrl.sv
module capseg_ctrl
    import capseg_pkg::*;
#(
    parameter int SMP_W     = 16,
    parameter int ADDR_W    = 10,
    parameter int BLK_LOG   = 5,
    parameter int PRE_BLK_W = 8,
    parameter int SEG_BLK_W = ADDR_W - BLK_LOG + 1,
    parameter int NSEG_W    = 8,
    parameter int GAP_LEN   = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm,
    input  logic [1:0]           cfg_mode,
    input  logic [PRE_BLK_W-1:0] cfg_pre_blk,
    input  logic [SEG_BLK_W-1:0] cfg_post_blk,
    input  logic [SEG_BLK_W-1:0] cfg_seg_blk,
    input  logic [NSEG_W-1:0]    cfg_seg_num,
    input  logic                 cfg_gate_lvl,
    input  logic                 smp_valid,
    input  logic [SMP_W-1:0]     smp_data,
    input  logic                 trig,
    input  logic                 gate,
    output logic                 wr_en,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [SMP_W-1:0]     wr_data,
    output logic                 armed,
    output logic                 triggered,
    output logic                 done,
    output logic                 missed,
    output logic                 tpos_valid,
    output logic [ADDR_W-1:0]    tpos_addr
);

    localparam int CNT_BASE = (ADDR_W > PRE_BLK_W + BLK_LOG) ? ADDR_W : PRE_BLK_W + BLK_LOG;
    localparam int CNT_W    = CNT_BASE + 1;
    localparam logic [CNT_W-1:0] GAP_CNT = CNT_W'(GAP_LEN);

    typedef struct packed {
        cap_state_e          st;
        logic [NSEG_W-1:0]   seg;
        logic [ADDR_W-1:0]   ptr;
        logic [ADDR_W-1:0]   base;
        logic [CNT_W-1:0]    cnt;
        logic                missed;
        logic                wr_en;
        logic [ADDR_W-1:0]   wr_addr;
        logic [SMP_W-1:0]    wr_data;
        logic                tp_vld;
        logic [ADDR_W-1:0]   tp_addr;
    } ctrl_t;

    ctrl_t q, d;

    logic [CNT_W-1:0] fill_need, post_len, seg_len;
    logic             hit, gate_on;

    capseg_len #(
        .ADDR_W(ADDR_W), .BLK_LOG(BLK_LOG), .PRE_BLK_W(PRE_BLK_W),
        .SEG_BLK_W(SEG_BLK_W), .CNT_W(CNT_W)
    ) i_len (
        .mode(cfg_mode), .pre_blk(cfg_pre_blk), .post_blk(cfg_post_blk),
        .seg_blk(cfg_seg_blk), .fill_need(fill_need), .post_len(post_len),
        .seg_len(seg_len)
    );

    capseg_event i_evt (
        .clk(clk), .rst_n(rst_n), .arm(arm), .mode(cfg_mode),
        .gate_lvl(cfg_gate_lvl), .smp_valid(smp_valid), .trig(trig),
        .gate(gate), .hit(hit), .gate_on(gate_on)
    );

    logic [ADDR_W-1:0] ptr_nx;
    logic [NSEG_W:0]   nseg;
    logic              last_seg;
    logic              seg_end;
    logic              rec_st;

    always_comb begin
        d        = q;
        d.wr_en  = 1'b0;
        d.tp_vld = 1'b0;
        seg_end  = 1'b0;

        ptr_nx   = ((CNT_W'(q.ptr) + CNT_W'(1)) == seg_len) ? '0 : q.ptr + ADDR_W'(1);
        nseg     = (cfg_mode == MODE_SINGLE) ? (NSEG_W+1)'(1) : {1'b0, cfg_seg_num};
        last_seg = (({1'b0, q.seg} + (NSEG_W+1)'(1)) == nseg);
        rec_st   = (q.st == ST_FILL) || (q.st == ST_ARMED) ||
                   (q.st == ST_POST) || (q.st == ST_GATE);

        if (arm) begin
            d.st     = ST_FILL;
            d.seg    = '0;
            d.ptr    = '0;
            d.base   = '0;
            d.cnt    = '0;
            d.missed = 1'b0;
        end else if (smp_valid) begin
            if (rec_st) begin
                d.wr_en   = 1'b1;
                d.wr_addr = q.base + q.ptr;
                d.wr_data = smp_data;
                d.ptr     = ptr_nx;
            end
            case (q.st)
                ST_GAP: begin
                    if (hit) d.missed = 1'b1;
                    if (q.cnt + CNT_W'(1) == GAP_CNT) begin
                        d.st  = ST_FILL;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_FILL: begin
                    if (hit) d.missed = 1'b1;
                    if (q.cnt + CNT_W'(1) == fill_need) begin
                        d.st  = ST_ARMED;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_ARMED: begin
                    if (hit) begin
                        d.tp_vld  = 1'b1;
                        d.tp_addr = q.base + q.ptr;
                        d.cnt     = CNT_W'(1);
                        d.st      = (cfg_mode == MODE_GATED) ? ST_GATE : ST_POST;
                    end
                end
                ST_GATE: begin
                    if (!gate_on) begin
                        d.st  = ST_POST;
                        d.cnt = CNT_W'(1);
                    end
                end
                ST_POST: begin
                    if (q.cnt + CNT_W'(1) == post_len) begin
                        seg_end = 1'b1;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
            if (seg_end) begin
                if (last_seg) begin
                    d.st = ST_DONE;
                end else begin
                    d.st   = ST_GAP;
                    d.seg  = q.seg + NSEG_W'(1);
                    d.base = q.base + seg_len[ADDR_W-1:0];
                    d.ptr  = '0;
                    d.cnt  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign wr_en      = q.wr_en;
    assign wr_addr    = q.wr_addr;
    assign wr_data    = q.wr_data;
    assign armed      = (q.st == ST_ARMED);
    assign triggered  = (q.st == ST_POST) || (q.st == ST_GATE);
    assign done       = (q.st == ST_DONE);
    assign missed     = q.missed;
    assign tpos_valid = q.tp_vld;
    assign tpos_addr  = q.tp_addr;

    p_status_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({armed, triggered, done}));

    p_write_follows_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(smp_valid) && wr_data == $past(smp_data)));

    p_done_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> !wr_en);

    p_gap_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_GAP && $past(q.st == ST_GAP)) |-> !wr_en);

    p_missed_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (missed && !arm) |=> missed);

    p_early_hit_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FILL && hit && !arm) |=> !triggered);

    p_tpos_with_trigger_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tpos_valid |-> (triggered && wr_en && wr_addr == tpos_addr && $past(armed)));

endmodule

// File: tb/test_capseg_ctrl.sv
module test_capseg_ctrl;

    localparam logic [15:0] SENT = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [7:0]  cfg_pre_blk = 8'd1;
    logic [5:0]  cfg_post_blk = 6'd1;
    logic [5:0]  cfg_seg_blk = 6'd4;
    logic [7:0]  cfg_seg_num = 8'd1;
    logic        cfg_gate_lvl = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        trig = 1'b0;
    logic        gate = 1'b1;
    logic        wr_en;
    logic [9:0]  wr_addr;
    logic [15:0] wr_data;
    logic        armed, triggered, done, missed, tpos_valid;
    logic [9:0]  tpos_addr;

    int errors = 0;
    int checks = 0;
    int wcount = 0;
    int tpn = 0;
    int tpos [0:7];
    logic [15:0] mem [0:1023];

    always #2 clk = ~clk;

    capseg_ctrl i_capseg_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_mode(cfg_mode),
        .cfg_pre_blk(cfg_pre_blk), .cfg_post_blk(cfg_post_blk),
        .cfg_seg_blk(cfg_seg_blk), .cfg_seg_num(cfg_seg_num),
        .cfg_gate_lvl(cfg_gate_lvl), .smp_valid(smp_valid), .smp_data(smp_data),
        .trig(trig), .gate(gate), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .armed(armed), .triggered(triggered), .done(done),
        .missed(missed), .tpos_valid(tpos_valid), .tpos_addr(tpos_addr)
    );

    always @(negedge clk) begin
        if (wr_en === 1'b1) begin
            mem[wr_addr] = wr_data;
            wcount++;
        end
        if (tpos_valid === 1'b1) begin
            if (tpn < 8) tpos[tpn] = int'(tpos_addr);
            tpn++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic v, input logic t, input logic g, input logic [15:0] dd);
        smp_valid = v;
        trig      = t;
        gate      = g;
        smp_data  = dd;
        @(posedge clk);
        #1;
    endtask

    task automatic clear_scoreboard();
        for (int i = 0; i < 1024; i++) mem[i] = SENT;
        wcount = 0;
        tpn    = 0;
    endtask

    task automatic do_arm(input logic g);
        arm = 1'b1;
        push(1'b1, 1'b1, g, 16'h1234);   // sample in the arm cycle is dropped
        arm = 1'b0;
        check("R9 arm clears done", int'(done), 0);
        check("R9 arm clears missed", int'(missed), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 armed", int'(armed), 0);
        check("R1 triggered", int'(triggered), 0);
        check("R1 done", int'(done), 0);
        check("R1 missed", int'(missed), 0);
        check("R1 tpos_valid", int'(tpos_valid), 0);
        clear_scoreboard();
        for (int k = 0; k < 5; k++) push(1'b1, 1'b1, 1'b1, 16'(k));
        push(1'b0, 1'b0, 1'b1, 16'h0);
        check("R1 no write before arm", wcount, 0);
    endtask

    task automatic t_single();
        cfg_mode     = 2'd0;
        cfg_post_blk = 6'd2;
        clear_scoreboard();
        do_arm(1'b1);
        check("R9 arm cycle sample not recorded", wcount, 0);
        for (int k = 0; k < 1100; k++) begin
            push(1'b1, (k == 500) || (k == 1000), 1'b1, 16'(k));
            if (k == 500) begin
                check("R7 early trigger sets missed", int'(missed), 1);
                check("R7 early trigger not taken", int'(triggered), 0);
            end
            if (k == 958) check("R3 not armed before ring minus post", int'(armed), 0);
            if (k == 959) check("R3 armed after ring minus post", int'(armed), 1);
            if (k == 1000) check("R11 triggered after trigger", int'(triggered), 1);
            if (k == 1062) check("R3 not done before last post sample", int'(done), 0);
            if (k == 1063) check("R3 done after post", int'(done), 1);
        end
        check("R3 write count", wcount, 1064);
        check("R3 trigger sample", int'(mem[1000]), 1000);
        check("R3 last post sample wraps", int'(mem[39]), 1063);
        check("R3 oldest pre kept", int'(mem[40]), 40);
        check("R10 one trigger position", tpn, 1);
        check("R10 trigger address", tpos[0], 1000);
        check("R11 done only", int'(armed) + int'(triggered), 0);
    endtask

    task automatic t_multi();
        cfg_mode     = 2'd1;
        cfg_pre_blk  = 8'd1;
        cfg_post_blk = 6'd2;
        cfg_seg_blk  = 6'd4;
        cfg_seg_num  = 8'd3;
        clear_scoreboard();
        do_arm(1'b1);
        for (int k = 0; k < 520; k++) begin
            if (k == 35) begin
                push(1'b0, 1'b1, 1'b1, 16'hAAAA);
                push(1'b0, 1'b1, 1'b1, 16'hAAAA);
                check("R2 invalid cycle trigger ignored", int'(triggered), 0);
                check("R2 invalid cycle not written", wcount, 35);
            end
            push(1'b1, (k == 40) || (k == 120) || (k == 176) || (k == 400), 1'b1, 16'(k));
            if (k == 31) check("R4 armed after one pre block", int'(armed), 1);
            if (k == 119) check("R7 missed clear before gap trigger", int'(missed), 0);
            if (k == 120) check("R6 gap trigger ignored sets missed", int'(missed), 1);
            if (k == 174) check("R6 not armed before gap plus pre", int'(armed), 0);
            if (k == 175) check("R6 armed after gap plus pre", int'(armed), 1);
            if (k == 462) check("R9 not done before last segment ends", int'(done), 0);
            if (k == 463) check("R9 done after last segment", int'(done), 1);
        end
        check("R5 write count", wcount, 384);
        check("R5 seg0 trigger", int'(mem[40]), 40);
        check("R5 seg0 last post", int'(mem[103]), 103);
        check("R6 gap samples not stored", int'(mem[104]), int'(SENT));
        check("R5 seg1 base holds first pre", int'(mem[128]), 144);
        check("R5 seg2 wrapped post end", int'(mem[311]), 463);
        check("R5 seg2 older sample after wrap", int'(mem[312]), 336);
        check("R9 no fourth segment", int'(mem[384]), int'(SENT));
        check("R10 trigger count", tpn, 3);
        check("R10 seg0 position", tpos[0], 40);
        check("R10 seg1 position", tpos[1], 160);
        check("R10 seg2 position", tpos[2], 376);
    endtask

    task automatic t_gated();
        logic g;
        cfg_mode     = 2'd2;
        cfg_gate_lvl = 1'b0;
        cfg_pre_blk  = 8'd1;
        cfg_post_blk = 6'd1;
        cfg_seg_blk  = 6'd4;
        cfg_seg_num  = 8'd2;
        clear_scoreboard();
        do_arm(1'b1);
        for (int k = 0; k < 260; k++) begin
            g = ((k >= 50 && k < 70) || (k >= 160 && k < 166) || (k >= 200 && k < 210)) ? 1'b0 : 1'b1;
            push(1'b1, 1'b0, g, 16'(k));
            if (k == 49) check("R8 armed waits for gate", int'(triggered), 0);
            if (k == 50) check("R8 gate start opens record", int'(triggered), 1);
            if (k == 85) check("R8 post area after gate end", int'(triggered), 1);
            if (k == 101) check("R6 record closed into gap", int'(triggered) + int'(armed), 0);
            if (k == 159) check("R7 missed clear before fill gate", int'(missed), 0);
            if (k == 160) check("R7 gate start in fill sets missed", int'(missed), 1);
            if (k == 241) check("R9 gated done", int'(done), 1);
        end
        check("R8 write count", wcount, 202);
        check("R8 last gate sample", int'(mem[69]), 69);
        check("R8 last post sample", int'(mem[101]), 101);
        check("R6 gated gap not stored", int'(mem[102]), int'(SENT));
        check("R5 gated seg1 base", int'(mem[128]), 142);
        check("R8 seg1 final post", int'(mem[227]), 241);
        check("R10 gated positions", tpn, 2);
        check("R10 gated first position", tpos[0], 50);
        check("R10 gated second position", tpos[1], 186);
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_multi();
        t_gated();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule